// File: doc/BRIEF.md
# Four-Cycle SIMD Cluster Sequencer

This block paces one SIMD array made of sixteen clusters, each holding five scalar ALU slots, through a 64-pixel batch. A bundle of up to five independent scalar operations is offered together with a slot-valid mask. Once accepted, the bundle is held for four clock cycles. In each of those cycles every cluster works on one of its own four pixels, so the sixteen clusters cover all 64 pixels in four cycles. The number of pixels in flight never changes. Only the number of scalar operations varies from bundle to bundle, from 0 to 5 per cluster per cycle, which gives at most 320 per bundle across the array.

For each cycle the sequencer drives a pixel index and a slot-enable vector to every cluster. It exposes the current phase and a pulse in the final phase of each bundle. It also totals the scalar operations carried out over a batch. A batch is closed by a bundle that carries the last flag, and the total for that batch is then published.

Top module: `simd_cadence_top`

## Requirements
- R1: After reset, `in_ready` is 1, `busy` is 0, `phase` is 0, every slot enable is 0, `batch_ops` is 0 and `batch_ops_valid` is 0.
- R2: A bundle is accepted at a rising edge where `in_valid` and `in_ready` are both 1. In the following cycle `busy` is 1 and `phase` is 0.
- R3: While busy, `phase` steps 0, 1, 2, 3 on consecutive cycles. The cycle after phase 3 is idle, with `busy` at 0 and `in_ready` at 1.
- R4: `in_ready` is 0 for all four phases. An offered bundle is ignored during those phases: neither the slot enables nor the phase sequence change.
- R5: The 6-bit pixel index for cluster c, at bits [6c+5:6c] of `pix_idx`, equals c*4 + `phase`.
- R6: For cluster c, slot enable bit s, at bit 5c+s of `slot_en`, equals bit s of the accepted mask in every busy cycle. All enables are 0 when idle.
- R7: `bundle_done` is 1 exactly in the phase-3 cycle of each bundle.
- R8: Each completed bundle adds (number of set mask bits) × 64 to the running total of its batch. A mask with no bits set still takes four cycles and adds 0.
- R9: In the idle cycle after the phase-3 cycle of a bundle that carries `in_last`=1, `batch_ops_valid` pulses for one cycle. `batch_ops` then shows the batch total and keeps it until the next batch closes. The running total restarts at 0.
- R10: A full five-slot bundle adds exactly 320, so a closed batch holding n full bundles reports 320·n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_mask | input | 5 | Slot-valid mask of offered bundle |
| in_last | input | 1 | Offered bundle closes the batch |
| in_ready | output | 1 | Sequencer can take a bundle this cycle |
| busy | output | 1 | A bundle is being applied |
| phase | output | 2 | Current pixel phase 0..3 |
| bundle_done | output | 1 | Final phase of a bundle |
| pix_idx | output | 96 | Sixteen 6-bit pixel indices, cluster 0 in the low bits |
| slot_en | output | 80 | Sixteen 5-bit slot enables, cluster 0 in the low bits |
| batch_ops | output | 16 | Scalar operation total of the last closed batch |
| batch_ops_valid | output | 1 | Pulse when `batch_ops` is updated |

## Verification
The hardest situation to reach from the ports is a bundle offered while the sequencer is still busy. It must be refused, and the mask in force must not be disturbed. To reach it, the stimulus holds `in_valid` high with the inverted mask during phases 0 to 2 and checks every cluster's enables on every phase. It drops the request just before the idle cycle, so that the intended bundle follows back to back. All 32 masks are swept, with batches closed every third bundle. A separate batch of eight full bundles exercises the upper end of the count.

// File: rtl/simd_seq_pkg.sv
package simd_seq_pkg;
    localparam int NUM_CLUSTERS = 16;
    localparam int NUM_SLOTS    = 5;
    localparam int NUM_PHASES   = 4;
    localparam int CNT_W        = 16;
    localparam int PH_W         = $clog2(NUM_PHASES);
    localparam int PIX_W        = $clog2(NUM_CLUSTERS * NUM_PHASES);
    localparam int OPS_PER_SLOT = NUM_CLUSTERS * NUM_PHASES;

    typedef struct packed {
        logic                 last;
        logic [NUM_SLOTS-1:0] mask;
    } bundle_t;

    function automatic logic [CNT_W-1:0] bundle_ops(input logic [NUM_SLOTS-1:0] m);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            n = n + CNT_W'(m[i]);
        end
        return n * CNT_W'(OPS_PER_SLOT);
    endfunction
endpackage

// File: rtl/phase_ctrl.sv
module phase_ctrl
    import simd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  bundle_t         in_bundle,
    output logic            in_ready,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output logic            last_phase,
    output bundle_t         cur_bundle
);
    localparam logic [PH_W-1:0] PH_MAX = PH_W'(NUM_PHASES - 1);

    assign in_ready   = !busy;
    assign last_phase = busy && (phase == PH_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            phase      <= '0;
            cur_bundle <= '0;
        end else if (!busy) begin
            phase <= '0;
            if (in_valid) begin
                busy       <= 1'b1;
                cur_bundle <= in_bundle;
            end
        end else if (phase == PH_MAX) begin
            busy  <= 1'b0;
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && phase == '0));
    p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_MAX) |=> (busy && phase == $past(phase) + 1'b1));
    p_idle_after_r3: assert property (@(posedge clk) disable iff (rst)
        last_phase |=> !busy);
    p_hold_bundle_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != '0) |-> $stable(cur_bundle));
endmodule

// File: rtl/cluster_fanout.sv
module cluster_fanout
    import simd_seq_pkg::*;
(
    input  logic                              busy,
    input  logic [PH_W-1:0]                   phase,
    input  logic [NUM_SLOTS-1:0]              mask,
    output logic [NUM_CLUSTERS*PIX_W-1:0]     pix_idx,
    output logic [NUM_CLUSTERS*NUM_SLOTS-1:0] slot_en
);
    for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : g_cluster
        assign pix_idx[c*PIX_W +: PIX_W]       = PIX_W'(c * NUM_PHASES) + PIX_W'(phase);
        assign slot_en[c*NUM_SLOTS +: NUM_SLOTS] = busy ? mask : '0;
    end
endmodule

// File: rtl/op_counter.sv
module op_counter
    import simd_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  bundle_t          bundle,
    output logic [CNT_W-1:0] batch_ops,
    output logic             batch_ops_valid
);
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] add;

    assign add = bundle_ops(bundle.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc             <= '0;
            batch_ops       <= '0;
            batch_ops_valid <= 1'b0;
        end else begin
            batch_ops_valid <= 1'b0;
            if (done) begin
                if (bundle.last) begin
                    batch_ops       <= acc + add;
                    acc             <= '0;
                    batch_ops_valid <= 1'b1;
                end else begin
                    acc <= acc + add;
                end
            end
        end
    end

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        batch_ops_valid |=> !batch_ops_valid);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !batch_ops_valid |-> $stable(batch_ops));
    p_bundle_bound_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (add <= CNT_W'(NUM_SLOTS * OPS_PER_SLOT)));
endmodule

// File: rtl/simd_cadence_top.sv
module simd_cadence_top
    import simd_seq_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [NUM_SLOTS-1:0]              in_mask,
    input  logic                              in_last,
    output logic                              in_ready,
    output logic                              busy,
    output logic [PH_W-1:0]                   phase,
    output logic                              bundle_done,
    output logic [NUM_CLUSTERS*PIX_W-1:0]     pix_idx,
    output logic [NUM_CLUSTERS*NUM_SLOTS-1:0] slot_en,
    output logic [CNT_W-1:0]                  batch_ops,
    output logic                              batch_ops_valid
);
    bundle_t in_b;
    bundle_t cur_b;

    assign in_b.last = in_last;
    assign in_b.mask = in_mask;

    phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_bundle  (in_b),
        .in_ready   (in_ready),
        .busy       (busy),
        .phase      (phase),
        .last_phase (bundle_done),
        .cur_bundle (cur_b)
    );

    cluster_fanout u_fan (
        .busy    (busy),
        .phase   (phase),
        .mask    (cur_b.mask),
        .pix_idx (pix_idx),
        .slot_en (slot_en)
    );

    op_counter u_cnt (
        .clk             (clk),
        .rst             (rst),
        .done            (bundle_done),
        .bundle          (cur_b),
        .batch_ops       (batch_ops),
        .batch_ops_valid (batch_ops_valid)
    );

    p_done_then_ready_r7: assert property (@(posedge clk) disable iff (rst)
        bundle_done |=> in_ready);
    p_idle_no_enable_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (slot_en == '0));
endmodule

// File: tb/simd_cadence_top_test.sv
module simd_cadence_top_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  in_mask;
    logic        in_last;
    logic        in_ready;
    logic        busy;
    logic [1:0]  phase;
    logic        bundle_done;
    logic [95:0] pix_idx;
    logic [79:0] slot_en;
    logic [15:0] batch_ops;
    logic        batch_ops_valid;

    int n_chk = 0;
    int n_bad = 0;
    int acc   = 0;
    int last_total = 0;

    always #2.5 clk = ~clk;

    simd_cadence_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mask(in_mask), .in_last(in_last),
        .in_ready(in_ready), .busy(busy), .phase(phase), .bundle_done(bundle_done),
        .pix_idx(pix_idx), .slot_en(slot_en), .batch_ops(batch_ops),
        .batch_ops_valid(batch_ops_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int ones(input logic [4:0] m);
        int n = 0;
        for (int i = 0; i < 5; i++) n += m[i];
        return n;
    endfunction

    // Offers a bundle at the current negedge (sequencer must be idle) and follows it through.
    task automatic run_bundle(input logic [4:0] m, input logic lst);
        in_valid = 1'b1; in_mask = m; in_last = lst;
        @(posedge clk); @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            chk("R2 busy", busy, 1);
            chk("R3 phase", phase, k);
            chk("R4 ready low", in_ready, 0);
            chk("R7 done", bundle_done, (k == 3));
            for (int c = 0; c < 16; c++) begin
                chk("R5 pix", pix_idx[c*6 +: 6], c*4 + k);
                chk("R6 en", slot_en[c*5 +: 5], m);
            end
            if (k < 3) begin
                in_valid = 1'b1; in_mask = ~m; in_last = ~lst;  // R4: must be ignored
            end else begin
                in_valid = 1'b0;
            end
            @(posedge clk); @(negedge clk);
        end
        acc += ones(m) * 64;
        chk("R3 idle", busy, 0);
        chk("R3 ready", in_ready, 1);
        chk("R6 idle en", (slot_en == '0), 1);
        chk("R9 valid", batch_ops_valid, lst);
        if (lst) begin
            chk("R8 R9 total", batch_ops, acc);
            last_total = acc;
            acc = 0;
        end else begin
            chk("R9 hold", batch_ops, last_total);
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                n_bad++; n_chk++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        join_none
        rst = 1'b1; in_valid = 1'b0; in_mask = '0; in_last = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1 ready", in_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 phase", phase, 0);
        chk("R1 en", (slot_en == '0), 1);
        chk("R1 ops", batch_ops, 0);
        chk("R1 valid", batch_ops_valid, 0);
        // idle gap with no request: stays idle
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R2 no accept", busy, 0);
        // sweep all masks, batch closes every third bundle (includes mask 0, R8)
        for (int m = 0; m < 32; m++) begin
            run_bundle(5'(m), (m % 3) == 2);
        end
        run_bundle(5'h0, 1'b1);  // close leftover batch
        // R10: eight full bundles in one batch
        for (int i = 0; i < 8; i++) run_bundle(5'h1f, i == 7);
        chk("R10 full batch", batch_ops, 2560);
        // R9: result holds while idle
        repeat (4) begin @(posedge clk); @(negedge clk); end
        chk("R9 held", batch_ops, 2560);
        chk("R9 no pulse", batch_ops_valid, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule